// File: doc/BRIEF.md
# Double-Banked Coefficient Register File

This block holds the tap weights of a 32-tap multiply-accumulate array in two physical banks. One bank is the live set and drives the per-tap outputs. The other bank is a staging set that a host can rewrite at any time without disturbing the arithmetic. A host port with a 7-bit word address reaches both banks, a configuration word and a swap-control word. Writes take effect on the clock edge. Reads are combinational from the address.

An exchange of the two banks can be requested once, through a self-clearing request bit. It can also happen automatically after every accepted input cycle, in continuous mode. Either way the exchange is aligned to the sampling point of the input-start signal, and it is a single-clock pointer flip. Before they leave the block, the live coefficients are sign-extended from a programmable width of 4, 8, 12 or 16 bits to 16 bits. Reset clears the control state but leaves both banks and the bank pointer as they were.

Top module: `cbank_file`

## Requirements
- R1: Addresses 0-31 reach the staging bank and addresses 32-63 reach the live bank, with entry k at offset k. A read returns the full stored 16-bit word. Live entry k drives tap k, which is bits [16k+15:16k] of `coef_taps`, so entry 0 is the lowest slice.
- R2: Address 64 is the configuration word: bits [1:0] select the width and bit 2 enables continuous mode. It resets to 3 (16 bits, one-shot). Address 65 bit 0 is the swap request and reads back as pending. Addresses 66-127 read as 0, and writes to them change nothing.
- R3: `coef_taps` changes only at an edge that swaps banks, writes the live bank, or writes the configuration word.
- R4: Writing 1 to address 65 bit 0 sets the request pending. The banks then exchange at the first edge where `smp_pt` is high, whatever the value of `go_in`, and the exchanged contents appear after that edge.
- R5: The pending request clears at the edge that performs its swap. Writing 0 to address 65 has no effect.
- R6: `busy` is high while a request is pending, and in any cycle whose closing edge performs a swap. It is low otherwise.
- R7: In continuous mode the banks exchange at every edge where `smp_pt` and `go_in` are both high. No exchange happens when `go_in` is low.
- R8: Width code 00 selects 4 bits, 01 selects 8, 10 selects 12 and 11 selects 16. Each tap is the low bits of its word taken as two's complement and sign-extended to 16 bits. The upper bits of the word are ignored.
- R9: A staging-bank write at the same edge as a swap goes into the bank that becomes live, so the value appears at that tap after the edge.
- R10: A request written at the same edge as a sampling point, with no request already pending, does not swap at that edge. It stays pending for the next sampling point.
- R11: Reset clears the request and the configuration word. It leaves both banks and their live/staging roles unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the control state |
| host_we | input | 1 | Host write strobe, one word per cycle |
| host_addr | input | 7 | Host word address |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Host read data for `host_addr` |
| smp_pt | input | 1 | Marks the clock edge at which the input-start signal is sampled |
| go_in | input | 1 | Input-start value sampled at `smp_pt` |
| busy | output | 1 | Exchange pending or happening this cycle |
| coef_taps | output | 512 | Live coefficients, sign-extended, tap k at bits [16k+15:16k] |

## Verification
A host write and a bank exchange can fall on the same edge. This happens either as a staging-bank write with a sampling point, or as a new swap request with a sampling point. The bench provokes each case directly, and also at random by raising `smp_pt` about one cycle in four while host writes go to random addresses. The results are judged at the ports. A staging write in a swap cycle must show up on the live tap. A request that coincides with a sampling point must stay pending and swap only at the next sampling point.

// File: rtl/cbank_pkg.sv
package cbank_pkg;
  localparam int COEF_W = 16;

  typedef enum logic [1:0] {
    WID_4  = 2'b00,
    WID_8  = 2'b01,
    WID_12 = 2'b10,
    WID_16 = 2'b11
  } wid_sel_t;

  // Sign-extend the low bits of a stored word, selected by the width code.
  function automatic logic [COEF_W-1:0] sext_coef(input logic [COEF_W-1:0] raw,
                                                  input wid_sel_t sel);
    logic [COEF_W-1:0] res;
    case (sel)
      WID_4:   res = {{12{raw[3]}},  raw[3:0]};
      WID_8:   res = {{8{raw[7]}},   raw[7:0]};
      WID_12:  res = {{4{raw[11]}},  raw[11:0]};
      default: res = raw;
    endcase
    return res;
  endfunction
endpackage

// File: rtl/cbank_swap_ctrl.sv
module cbank_swap_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic smp_pt,
  input  logic go_in,
  input  logic cont_mode,
  input  logic req_set,
  output logic cur_ptr,
  output logic pending,
  output logic busy,
  output logic swap_evt
);
  // Exchange fires at a sampling point: a pending one-shot, or an accepted
  // input cycle in continuous mode.
  assign swap_evt = smp_pt && (pending || (cont_mode && go_in));
  assign busy     = pending || swap_evt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending <= 1'b0;
    end else if (req_set) begin
      pending <= 1'b1;
    end else if (swap_evt) begin
      pending <= 1'b0;
    end
  end

  // Bank pointer deliberately kept across reset so bank roles survive it.
  always_ff @(posedge clk) begin
    if (swap_evt) cur_ptr <= ~cur_ptr;
  end

  p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !smp_pt) |=> pending);

  p_req_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && smp_pt && !req_set) |=> !pending);

  p_cont_swap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cont_mode && smp_pt && go_in) |=> (cur_ptr != $past(cur_ptr)));

  p_req_new_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_set |=> pending);

  p_busy_pending_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pending) |-> busy);
endmodule

// File: rtl/cbank_regs.sv
module cbank_regs #(
  parameter int NTAPS = 32,
  parameter int IW    = $clog2(NTAPS)
) (
  input  logic                                  clk,
  input  logic                                  cur_ptr,
  input  logic                                  wr_en,
  input  logic                                  wr_cur,
  input  logic [IW-1:0]                         wr_idx,
  input  logic [cbank_pkg::COEF_W-1:0]          wr_data,
  input  logic                                  rd_cur,
  input  logic [IW-1:0]                         rd_idx,
  output logic [cbank_pkg::COEF_W-1:0]          rd_data,
  output logic [NTAPS*cbank_pkg::COEF_W-1:0]    cur_flat
);
  localparam int W = cbank_pkg::COEF_W;

  logic [W-1:0] bank_q [2][NTAPS];
  logic         wr_phys;
  logic         rd_phys;

  // Host view maps through the pointer: live region -> cur_ptr bank.
  assign wr_phys = wr_cur ? cur_ptr : ~cur_ptr;
  assign rd_phys = rd_cur ? cur_ptr : ~cur_ptr;

  always_ff @(posedge clk) begin
    if (wr_en) bank_q[wr_phys][wr_idx] <= wr_data;
  end

  assign rd_data = bank_q[rd_phys][rd_idx];

  for (genvar t = 0; t < NTAPS; t++) begin : g_live
    assign cur_flat[t*W +: W] = bank_q[cur_ptr][t];
  end
endmodule

// File: rtl/cbank_sext.sv
module cbank_sext #(
  parameter int NTAPS = 32
) (
  input  logic [NTAPS*cbank_pkg::COEF_W-1:0] raw_flat,
  input  cbank_pkg::wid_sel_t                wsel,
  output logic [NTAPS*cbank_pkg::COEF_W-1:0] tap_flat
);
  localparam int W = cbank_pkg::COEF_W;

  for (genvar t = 0; t < NTAPS; t++) begin : g_tap
    assign tap_flat[t*W +: W] = cbank_pkg::sext_coef(raw_flat[t*W +: W], wsel);
  end
endmodule

// File: rtl/cbank_file.sv
module cbank_file #(
  parameter int NTAPS = 32,
  parameter int IW    = $clog2(NTAPS),
  parameter int AW    = IW + 2
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                host_we,
  input  logic [AW-1:0]                       host_addr,
  input  logic [cbank_pkg::COEF_W-1:0]        host_wdata,
  output logic [cbank_pkg::COEF_W-1:0]        host_rdata,
  input  logic                                smp_pt,
  input  logic                                go_in,
  output logic                                busy,
  output logic [NTAPS*cbank_pkg::COEF_W-1:0]  coef_taps
);
  import cbank_pkg::*;
  localparam int W = COEF_W;
  localparam logic [AW-1:0] CFG_ADDR = AW'(2 * NTAPS);
  localparam logic [AW-1:0] CTL_ADDR = AW'(2 * NTAPS + 1);

  wid_sel_t      wsel_q;
  logic          cont_q;
  logic          in_banks;
  logic          bank_wr;
  logic          cur_wr;
  logic          cfg_wr;
  logic          req_set;
  logic          cur_ptr;
  logic          pending;
  logic          swap_evt;
  logic [W-1:0]  bank_rd;
  logic [NTAPS*W-1:0] raw_flat;

  // Address decode: top bit clear means one of the two banks.
  assign in_banks = !host_addr[AW-1];
  assign bank_wr  = host_we && in_banks;
  assign cur_wr   = bank_wr && host_addr[IW];
  assign cfg_wr   = host_we && (host_addr == CFG_ADDR);
  assign req_set  = host_we && (host_addr == CTL_ADDR) && host_wdata[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wsel_q <= WID_16;
      cont_q <= 1'b0;
    end else if (cfg_wr) begin
      wsel_q <= wid_sel_t'(host_wdata[1:0]);
      cont_q <= host_wdata[2];
    end
  end

  cbank_swap_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_pt    (smp_pt),
    .go_in     (go_in),
    .cont_mode (cont_q),
    .req_set   (req_set),
    .cur_ptr   (cur_ptr),
    .pending   (pending),
    .busy      (busy),
    .swap_evt  (swap_evt)
  );

  cbank_regs #(.NTAPS(NTAPS), .IW(IW)) u_regs (
    .clk      (clk),
    .cur_ptr  (cur_ptr),
    .wr_en    (bank_wr),
    .wr_cur   (host_addr[IW]),
    .wr_idx   (host_addr[IW-1:0]),
    .wr_data  (host_wdata),
    .rd_cur   (host_addr[IW]),
    .rd_idx   (host_addr[IW-1:0]),
    .rd_data  (bank_rd),
    .cur_flat (raw_flat)
  );

  cbank_sext #(.NTAPS(NTAPS)) u_sext (
    .raw_flat (raw_flat),
    .wsel     (wsel_q),
    .tap_flat (coef_taps)
  );

  always_comb begin
    if (in_banks)                    host_rdata = bank_rd;
    else if (host_addr == CFG_ADDR)  host_rdata = {{(W-3){1'b0}}, cont_q, wsel_q};
    else if (host_addr == CTL_ADDR)  host_rdata = {{(W-1){1'b0}}, pending};
    else                             host_rdata = '0;
  end

  p_taps_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!swap_evt && !cur_wr && !cfg_wr) |=> $stable(coef_taps));

  p_busy_swap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_pt && pending) |-> busy);
endmodule

// File: tb/cbank_file_bench.sv
module cbank_file_bench;
  localparam int PER = 10;
  localparam int NT  = 32;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            host_we = 1'b0;
  logic [6:0]      host_addr = '0;
  logic [15:0]     host_wdata = '0;
  logic [15:0]     host_rdata;
  logic            smp_pt = 1'b0;
  logic            go_in = 1'b0;
  logic            busy;
  logic [NT*16-1:0] coef_taps;

  int n_chk = 0;
  int n_bad = 0;

  logic [15:0] upd_m [NT];
  logic [15:0] cur_m [NT];
  logic [1:0]  wsel_m = 2'b11;
  logic        cont_m = 1'b0;
  logic        pend_m = 1'b0;

  always #(PER/2) clk = ~clk;

  cbank_file u_cbank_file (
    .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .smp_pt(smp_pt),
    .go_in(go_in), .busy(busy), .coef_taps(coef_taps)
  );

  // Width sign extension by arithmetic shift.
  function automatic logic [15:0] ref_sext(input logic [15:0] v, input logic [1:0] s);
    int sh;
    sh = 12 - 4 * int'(s);
    return 16'($signed(v << sh) >>> sh);
  endfunction

  function automatic logic [NT*16-1:0] exp_taps();
    logic [NT*16-1:0] f;
    for (int i = 0; i < NT; i++) f[i*16 +: 16] = ref_sext(cur_m[i], wsel_m);
    return f;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_taps(input string req);
    logic [NT*16-1:0] e;
    e = exp_taps();
    n_chk++;
    if (coef_taps !== e) begin
      n_bad++;
      $display("FAIL %s taps actual=%0h expected=%0h", req, coef_taps, e);
    end
  endtask

  task automatic rd_chk(input string req, input logic [6:0] a, input logic [15:0] exp);
    host_addr = a;
    #1;
    chk(req, 32'(host_rdata), 32'(exp));
  endtask

  // One clock: drive at negedge, check busy, update model at the edge.
  task automatic step(input logic we, input logic [6:0] a, input logic [15:0] d,
                      input logic smp, input logic go);
    logic sw;
    host_we = we; host_addr = a; host_wdata = d; smp_pt = smp; go_in = go;
    #1;
    sw = smp && (pend_m || (cont_m && go));
    chk("R6 busy", 32'(busy), 32'(pend_m || sw));
    @(posedge clk);
    if (we) begin
      if (a < 7'd32)       upd_m[a[4:0]] = d;
      else if (a < 7'd64)  cur_m[a[4:0]] = d;
      else if (a == 7'd64) begin wsel_m = d[1:0]; cont_m = d[2]; end
    end
    if (sw) begin
      for (int i = 0; i < NT; i++) begin
        logic [15:0] t;
        t = upd_m[i]; upd_m[i] = cur_m[i]; cur_m[i] = t;
      end
    end
    if (we && a == 7'd65 && d[0]) pend_m = 1'b1;
    else if (sw)                  pend_m = 1'b0;
    @(negedge clk);
    host_we = 1'b0; smp_pt = 1'b0; go_in = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    pend_m = 1'b0; wsel_m = 2'b11; cont_m = 1'b0;
  endtask

  initial begin
    #(PER * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0c0f));
    @(negedge clk);
    do_reset();
    // R2 / R5 / R6: reset state
    rd_chk("R2 cfg reset", 7'd64, 16'd3);
    rd_chk("R5 req reset", 7'd65, 16'd0);
    chk("R6 busy idle", 32'(busy), 32'd0);

    // R1: fill both banks and read them back
    for (int i = 0; i < NT; i++) step(1'b1, 7'(i), 16'($urandom), 1'b0, 1'b0);
    for (int i = 0; i < NT; i++) step(1'b1, 7'(32 + i), 16'($urandom), 1'b0, 1'b0);
    rd_chk("R1 staging read", 7'd3, upd_m[3]);
    rd_chk("R1 live read", 7'd45, cur_m[13]);
    chk_taps("R1 live taps");

    // R2: unmapped write ignored, unmapped read zero
    step(1'b1, 7'd70, 16'hffff, 1'b0, 1'b0);
    rd_chk("R2 unmapped read", 7'd70, 16'd0);
    rd_chk("R2 cfg unchanged", 7'd64, 16'd3);
    rd_chk("R2 req unchanged", 7'd65, 16'd0);
    chk_taps("R2 taps unchanged");

    // R4 / R3: request waits for sampling point
    step(1'b1, 7'd65, 16'd1, 1'b0, 1'b0);
    step(1'b0, 7'd0, 16'd0, 1'b0, 1'b0);
    rd_chk("R4 pending", 7'd65, 16'd1);
    chk("R6 busy pending", 32'(busy), 32'd1);
    chk_taps("R3 no swap before sample");
    step(1'b0, 7'd0, 16'd0, 1'b1, 1'b0);
    chk_taps("R4 swap with go low");
    rd_chk("R5 cleared", 7'd65, 16'd0);
    rd_chk("R4 old live now staging", 7'd2, upd_m[2]);
    step(1'b1, 7'd65, 16'd0, 1'b1, 1'b1);
    rd_chk("R5 write zero ignored", 7'd65, 16'd0);
    chk_taps("R5 no swap on zero write");

    // R8: widths
    step(1'b1, 7'd32, 16'hab98, 1'b0, 1'b0);
    step(1'b1, 7'd33, 16'h5a37, 1'b0, 1'b0);
    for (int w = 0; w < 4; w++) begin
      step(1'b1, 7'd64, 16'(w), 1'b0, 1'b0);
      chk_taps("R8 width");
      chk("R8 tap0", 32'(coef_taps[15:0]), 32'(ref_sext(16'hab98, 2'(w))));
    end

    // R7: continuous mode
    step(1'b1, 7'd64, 16'd7, 1'b0, 1'b0);
    step(1'b0, 7'd0, 16'd0, 1'b1, 1'b0);
    chk_taps("R7 no swap with go low");
    step(1'b0, 7'd0, 16'd0, 1'b1, 1'b1);
    chk_taps("R7 swap with go high");
    step(1'b0, 7'd0, 16'd0, 1'b1, 1'b1);
    chk_taps("R7 second swap");
    step(1'b1, 7'd64, 16'd3, 1'b0, 1'b0);

    // R9: staging write on swap edge lands in new live bank
    step(1'b1, 7'd65, 16'd1, 1'b0, 1'b0);
    step(1'b1, 7'd5, 16'h8421, 1'b1, 1'b0);
    chk("R9 tap5", 32'(coef_taps[5*16 +: 16]), 32'h8421);
    chk_taps("R9 taps");

    // R10: request coinciding with sample, none pending
    step(1'b1, 7'd65, 16'd1, 1'b1, 1'b1);
    chk_taps("R10 no swap same edge");
    rd_chk("R10 still pending", 7'd65, 16'd1);
    step(1'b0, 7'd0, 16'd0, 1'b1, 1'b0);
    chk_taps("R10 swap next sample");

    // R11: reset keeps banks and roles
    step(1'b1, 7'd64, 16'd1, 1'b0, 1'b0);
    step(1'b1, 7'd65, 16'd1, 1'b0, 1'b0);
    do_reset();
    rd_chk("R11 cfg cleared", 7'd64, 16'd3);
    rd_chk("R11 req cleared", 7'd65, 16'd0);
    chk_taps("R11 live kept");
    for (int i = 0; i < NT; i += 7) rd_chk("R11 staging kept", 7'(i), upd_m[i]);

    // Random mix
    for (int k = 0; k < 600; k++) begin
      logic [6:0]  a;
      logic [15:0] d;
      logic        we;
      a  = 7'($urandom_range(0, 70));
      d  = 16'($urandom);
      we = ($urandom_range(0, 2) != 0);
      if (a == 7'd64) d[2] = ($urandom_range(0, 3) == 0) && !pend_m;
      if (a == 7'd65 && cont_m) d[0] = 1'b0;
      step(we, a, d, $urandom_range(0, 3) == 0, 1'($urandom));
      chk_taps("R3 random taps");
      rd_chk("R1 random read", 7'd65, 16'(pend_m));
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule